// File: doc/BRIEF.md
# Smart Card Power Sequencer

This block steps a contact smart card through power-up and power-down in the order that ISO 7816-3 requires. Firmware selects the on-chip card interface and writes a nonzero supply-level code. The sequencer then enables the supply and waits for a supply-good status, bounded by a programmable timeout. Once the supply is good it releases the I/O line and then gates on the card clock. After a programmable number of card clocks it lifts RST and pulses a marker that starts the answer-to-reset wait. The answer itself is handled elsewhere.

All sequencing is counted in card clock cycles. A one-system-clock `tick` strobe marks each card clock period. A reset-hold bit can pull RST back low during a session, and clearing the bit releases RST again after the programmed delay. Card removal, over-current, loss of supply-good after the I/O stage, or a firmware deactivate command all start the power-down path. That path drops RST, then CLK, then I/O and the auxiliary contacts, then the supply, and then raises a completion interrupt.

Top module: `sc_power_seq`

## Requirements
- R1: After reset every output is low and `status` is 0 (idle).
- R2: Activation starts from idle only when `if_sel`=1, `vsel`≠0 (1, 2 and 3 select 1.8 V, 3.0 V and 5.0 V), and `vsel` has been 0 at some point since the previous activation began. One cycle later `vcc_en`=1 and `status`=1. Before a first activation, the reset state counts as having seen 0.
- R3: From the start of activation the block counts ticks. If the count has reached `t_vcc_to` while `vcc_ok`=0, it pulses `irq_vcc_to` for one cycle and enters deactivation.
- R4: The supply-ready point is the first cycle with `vcc_ok`=1 when `rdy_start`=1, or the first cycle with `vcc_ok`=1 and an expired count when `rdy_start`=0. `io_en` rises on the second tick after that point.
- R5: `clk_gate` rises on the second tick after `io_en` rises.
- R6: After `clk_gate` rises, `card_rst` goes high on tick number max(`t_rst_dly`,1), together with a one-cycle `atr_start` pulse, and `status` becomes 2.
- R7: `rst_hold`=1 while active drives `card_rst` low on the next cycle. While the bit stays set, `card_rst` stays low. After it clears, `card_rst` rises again on tick number max(`t_rst_dly`,1).
- R8: `card_gone`, `over_curr` or `deact_cmd` during activation or an active session, or `vcc_ok`=0 once the I/O stage is reached, sets `card_rst`=0 and `status`=3 on the next cycle. This takes priority over any activation step due in the same cycle.
- R9: In deactivation, `clk_gate` falls on the first tick, `io_en` falls on the second tick, and `vcc_en` falls on the third tick. On that third tick a one-cycle `irq_deact` pulse is raised and `status` returns to 0.
- R10: `aux_en` always equals `io_en`, so both auxiliary contacts go low together with I/O.
- R11: `status` encodes 0 idle, 1 activating (including a reset re-hold), 2 active and 3 deactivating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe per card clock period |
| if_sel | input | 1 | Selects the on-chip card interface |
| vsel | input | 2 | Supply level code, 0 = off |
| vcc_ok | input | 1 | Supply-good status |
| rdy_start | input | 1 | 1: I/O interval starts at supply-good; 0: waits for timer expiry too |
| rst_hold | input | 1 | Holds card RST low while set |
| card_gone | input | 1 | Card removal fault |
| over_curr | input | 1 | Supply over-current fault |
| deact_cmd | input | 1 | Firmware deactivate command |
| t_rst_dly | input | DLY_W | Card clocks from clock start to RST release |
| t_vcc_to | input | TO_W | Card clocks allowed for supply-good |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | I/O line released high |
| aux_en | output | 1 | Auxiliary contacts enable |
| clk_gate | output | 1 | Card clock running |
| card_rst | output | 1 | Card RST level (0 = in reset) |
| atr_start | output | 1 | Pulse: start of the answer-to-reset wait |
| irq_vcc_to | output | 1 | Pulse: supply-good timeout |
| irq_deact | output | 1 | Pulse: deactivation finished |
| status | output | 2 | Sequencer phase |

## Verification
A fault and the RST release can fall in the same cycle, and so can the supply timeout expiry and supply-good. The bench provokes the first case by watching its own model. When the model predicts that the next tick completes the reset delay, the bench raises `deact_cmd` for that edge. It then expects `card_rst` to stay low, no `atr_start` pulse, and `status`=3. The second case is provoked by raising `vcc_ok` in the cycle in which the count reaches `t_vcc_to`. The per-clock model comparison then decides whether the design took the I/O path rather than the timeout path.

// File: rtl/sc_power_seq.sv
module sc_power_seq #(
  parameter int DLY_W = 16,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             if_sel,
  input  logic [1:0]       vsel,
  input  logic             vcc_ok,
  input  logic             rdy_start,
  input  logic             rst_hold,
  input  logic             card_gone,
  input  logic             over_curr,
  input  logic             deact_cmd,
  input  logic [DLY_W-1:0] t_rst_dly,
  input  logic [TO_W-1:0]  t_vcc_to,
  output logic             vcc_en,
  output logic             io_en,
  output logic             aux_en,
  output logic             clk_gate,
  output logic             card_rst,
  output logic             atr_start,
  output logic             irq_vcc_to,
  output logic             irq_deact,
  output logic [1:0]       status
);

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_IOW, S_CKW, S_RSW, S_ACT, S_DRST, S_DCLK, S_DIO
  } st_t;

  st_t              st;
  logic [DLY_W-1:0] cnt;
  logic [TO_W-1:0]  tcnt;
  logic             lock;

  logic             io_stage, fault, to_hit, rst_done;
  logic [DLY_W-1:0] dly_eff;
  logic [DLY_W:0]   cnt_nx;

  assign io_stage = (st == S_IOW) || (st == S_CKW) || (st == S_RSW) || (st == S_ACT);
  assign fault    = ((st == S_PWR) || io_stage) &&
                    (card_gone || over_curr || deact_cmd || (io_stage && !vcc_ok));
  assign to_hit   = tcnt >= t_vcc_to;
  assign dly_eff  = (t_rst_dly == '0) ? DLY_W'(1) : t_rst_dly;
  assign cnt_nx   = {1'b0, cnt} + 1'b1;
  assign rst_done = cnt_nx >= {1'b0, dly_eff};
  assign aux_en   = io_en;

  always_comb begin
    case (st)
      S_IDLE:                status = 2'd0;
      S_ACT:                 status = 2'd2;
      S_DRST, S_DCLK, S_DIO: status = 2'd3;
      default:               status = 2'd1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      tcnt       <= '0;
      lock       <= 1'b0;
      vcc_en     <= 1'b0;
      io_en      <= 1'b0;
      clk_gate   <= 1'b0;
      card_rst   <= 1'b0;
      atr_start  <= 1'b0;
      irq_vcc_to <= 1'b0;
      irq_deact  <= 1'b0;
    end else begin
      atr_start  <= 1'b0;
      irq_vcc_to <= 1'b0;
      irq_deact  <= 1'b0;
      if (vsel == 2'd0) lock <= 1'b0;

      if (fault) begin
        card_rst <= 1'b0;
        st       <= S_DRST;
      end else begin
        case (st)
          S_IDLE:
            if (if_sel && vsel != 2'd0 && !lock) begin
              lock   <= 1'b1;
              vcc_en <= 1'b1;
              tcnt   <= '0;
              st     <= S_PWR;
            end
          S_PWR:
            if (to_hit && !vcc_ok) begin
              irq_vcc_to <= 1'b1;
              st         <= S_DRST;
            end else if (vcc_ok && (rdy_start || to_hit)) begin
              cnt <= '0;
              st  <= S_IOW;
            end else if (tick && tcnt != '1) begin
              tcnt <= tcnt + 1'b1;
            end
          S_IOW:
            if (tick) begin
              if (cnt == DLY_W'(1)) begin
                io_en <= 1'b1;
                cnt   <= '0;
                st    <= S_CKW;
              end else cnt <= cnt + 1'b1;
            end
          S_CKW:
            if (tick) begin
              if (cnt == DLY_W'(1)) begin
                clk_gate <= 1'b1;
                cnt      <= '0;
                st       <= S_RSW;
              end else cnt <= cnt + 1'b1;
            end
          S_RSW:
            if (rst_hold) cnt <= '0;
            else if (tick) begin
              if (rst_done) begin
                card_rst  <= 1'b1;
                atr_start <= 1'b1;
                st        <= S_ACT;
              end else cnt <= cnt_nx[DLY_W-1:0];
            end
          S_ACT:
            if (rst_hold) begin
              card_rst <= 1'b0;
              cnt      <= '0;
              st       <= S_RSW;
            end
          S_DRST:
            if (tick) begin
              clk_gate <= 1'b0;
              st       <= S_DCLK;
            end
          S_DCLK:
            if (tick) begin
              io_en <= 1'b0;
              st    <= S_DIO;
            end
          S_DIO:
            if (tick) begin
              vcc_en    <= 1'b0;
              irq_deact <= 1'b1;
              st        <= S_IDLE;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sc_power_seq_chk.sv
module sc_power_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] vsel,
  input logic       rst_hold,
  input logic       card_gone,
  input logic       over_curr,
  input logic       deact_cmd,
  input logic       vcc_en,
  input logic       io_en,
  input logic       clk_gate,
  input logic       card_rst,
  input logic       atr_start,
  input logic       irq_deact,
  input logic [1:0] status
);

  assert_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_gate |-> io_en) and (io_en |-> vcc_en) and (card_rst |-> clk_gate));

  assert_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == 2'd1 || status == 2'd2) && (card_gone || over_curr || deact_cmd))
      |=> (!card_rst && status == 2'd3));

  assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en) |-> (irq_deact && status == 2'd0));

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_deact |=> !irq_deact);

  assert_atr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    atr_start |-> ($rose(card_rst) && status == 2'd2));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2 && rst_hold) |=> !card_rst);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd0 && vsel == 2'd0) |=> (status == 2'd0 && !vcc_en));

endmodule

bind sc_power_seq sc_power_seq_chk chk_i (.*);

// File: tb/sc_power_seq_test.sv
`timescale 1ns/100ps
module sc_power_seq_test;
  logic clk = 0, rst_n = 0, tick = 0;
  logic if_sel = 0, vcc_ok = 0, rdy_start = 1, rst_hold = 0;
  logic card_gone = 0, over_curr = 0, deact_cmd = 0;
  logic [1:0] vsel = 0;
  logic [15:0] t_rst_dly = 16'd5, t_vcc_to = 16'd6;
  logic vcc_en, io_en, aux_en, clk_gate, card_rst, atr_start, irq_vcc_to, irq_deact;
  logic [1:0] status;

  int checks = 0, errors = 0, cyc = 0;

  sc_power_seq uut (.*);

  always #2.5 clk = ~clk;

  // reference model: phases 0 idle,1 pwr,2 iowait,3 clkwait,4 rstwait,5 active,6-8 power-down steps
  int m_ph = 0, m_cnt = 0, m_t = 0;
  bit m_lock = 0;
  bit e_vcc = 0, e_io = 0, e_clk = 0, e_rst = 0, e_atr = 0, e_to = 0, e_dn = 0;

  function automatic int m_status(int p);
    if (p == 0) return 0;
    if (p == 5) return 2;
    if (p >= 6) return 3;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_t = 0; m_lock = 0;
      {e_vcc, e_io, e_clk, e_rst, e_atr, e_to, e_dn} = '0;
    end else begin
      int d;
      bit flt;
      d = (t_rst_dly == 0) ? 1 : int'(t_rst_dly);
      e_atr = 0; e_to = 0; e_dn = 0;
      flt = (m_ph >= 1 && m_ph <= 5) &&
            (card_gone || over_curr || deact_cmd || (m_ph >= 2 && !vcc_ok));
      if (vsel == 0) m_lock = 0;
      if (flt) begin
        e_rst = 0; m_ph = 6;
      end else if (m_ph == 0) begin
        if (if_sel && vsel != 0 && !m_lock) begin
          m_lock = 1; e_vcc = 1; m_t = 0; m_ph = 1;
        end
      end else if (m_ph == 1) begin
        if (m_t >= int'(t_vcc_to) && !vcc_ok) begin e_to = 1; m_ph = 6; end
        else if (vcc_ok && (rdy_start || m_t >= int'(t_vcc_to))) begin m_cnt = 0; m_ph = 2; end
        else if (tick) m_t++;
      end else if (m_ph == 2 || m_ph == 3) begin
        if (tick) begin
          m_cnt++;
          if (m_cnt == 2) begin
            if (m_ph == 2) e_io = 1; else e_clk = 1;
            m_cnt = 0; m_ph++;
          end
        end
      end else if (m_ph == 4) begin
        if (rst_hold) m_cnt = 0;
        else if (tick) begin
          m_cnt++;
          if (m_cnt >= d) begin e_rst = 1; e_atr = 1; m_ph = 5; end
        end
      end else if (m_ph == 5) begin
        if (rst_hold) begin e_rst = 0; m_cnt = 0; m_ph = 4; end
      end else if (tick) begin
        if (m_ph == 6) begin e_clk = 0; m_ph = 7; end
        else if (m_ph == 7) begin e_io = 0; m_ph = 8; end
        else begin e_vcc = 0; e_dn = 1; m_ph = 0; end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tick <= (cyc % 3 == 0);
    if (rst_n) begin
      chk(vcc_en == e_vcc, "R2 vcc_en", vcc_en, e_vcc);
      chk(irq_vcc_to == e_to, "R3 irq_vcc_to", irq_vcc_to, e_to);
      chk(io_en == e_io, "R4 io_en", io_en, e_io);
      chk(clk_gate == e_clk, "R5 clk_gate", clk_gate, e_clk);
      chk(card_rst == e_rst, "R6 card_rst", card_rst, e_rst);
      chk(atr_start == e_atr, "R6 atr_start", atr_start, e_atr);
      chk(irq_deact == e_dn, "R9 irq_deact", irq_deact, e_dn);
      chk(aux_en == io_en, "R10 aux_en", aux_en, io_en);
      chk(int'(status) == m_status(m_ph), "R11 status", status, m_status(m_ph));
    end
  end

  task automatic wait_ph(int p);
    for (int i = 0; i < 2000 && m_ph != p; i++) @(negedge clk);
    chk(m_ph == p, "model phase reached", m_ph, p);
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    settle(2);
    chk({vcc_en, io_en, aux_en, clk_gate, card_rst, atr_start, irq_vcc_to, irq_deact} == 0,
        "R1 outputs at reset", {vcc_en, io_en, clk_gate, card_rst}, 0);
    chk(status == 0, "R1 status at reset", status, 0);
    rst_n = 1;
    settle(3);

    // R2: no start without interface select
    vsel = 2; settle(10);
    chk(vcc_en == 0, "R2 no start without if_sel", vcc_en, 0);
    if_sel = 1; settle(12);
    vcc_ok = 1;                       // R4 with rdy_start=1
    wait_ph(5);
    settle(2);
    chk(card_rst == 1 && status == 2, "R6 active with RST high", status, 2);
    // R7 reset hold
    rst_hold = 1; settle(1);
    chk(card_rst == 0, "R7 hold drives RST low", card_rst, 0);
    settle(15);
    chk(card_rst == 0, "R7 RST stays low while held", card_rst, 0);
    rst_hold = 0;
    wait_ph(5); settle(3);
    chk(card_rst == 1, "R7 RST re-released", card_rst, 1);
    card_gone = 1; settle(1); card_gone = 0;
    chk(status == 3 && card_rst == 0, "R8 removal starts power-down", status, 3);
    wait_ph(0); settle(3);
    chk(vcc_en == 0, "R9 supply off after power-down", vcc_en, 0);

    // R2 lock: vsel not cleared -> no restart
    settle(20);
    chk(status == 0, "R2 locked until vsel cleared", status, 0);
    vsel = 0; settle(2); vsel = 3;
    rdy_start = 0; t_vcc_to = 6; t_rst_dly = 0;
    settle(2);
    chk(vcc_en == 1, "R2 restart after clear", vcc_en, 1);
    settle(4);
    chk(io_en == 0, "R4 waits for timer with rdy_start=0", io_en, 0);
    wait_ph(5); settle(2);
    over_curr = 1; settle(1); over_curr = 0;
    chk(status == 3, "R8 over-current power-down", status, 3);
    wait_ph(0); settle(3);

    // R3 timeout
    vsel = 0; vcc_ok = 0; t_vcc_to = 4; settle(2); vsel = 1;
    settle(1);
    wait_ph(6); settle(1);
    chk(status == 3, "R3 timeout enters power-down", status, 3);
    wait_ph(0); settle(3);

    // R8 collision: deactivate command on the RST release edge
    vsel = 0; rdy_start = 1; t_rst_dly = 7; settle(2);
    vsel = 2; vcc_ok = 1;
    wait_ph(4);
    for (int i = 0; i < 500; i++) begin
      @(posedge clk); #3;
      if (m_ph == 4 && tick && !rst_hold && m_cnt + 1 >= int'(t_rst_dly)) begin
        deact_cmd = 1;
        break;
      end
    end
    @(posedge clk); #1;
    deact_cmd = 0;
    chk(card_rst == 0 && atr_start == 0, "R8 fault beats RST release", card_rst, 0);
    chk(status == 3, "R8 status on collision", status, 3);
    wait_ph(0); settle(3);

    // R3/R4 collision: supply-good arrives as the count expires
    vsel = 0; vcc_ok = 0; rdy_start = 0; t_vcc_to = 3; t_rst_dly = 2; settle(2);
    vsel = 1;
    for (int i = 0; i < 500; i++) begin
      @(posedge clk); #3;
      if (m_ph == 1 && m_t >= int'(t_vcc_to) - 1 && tick) break;
    end
    vcc_ok = 1;
    settle(3);
    chk(irq_vcc_to == 0 || status != 3, "R4 good supply at expiry avoids timeout", status, 1);
    wait_ph(5); settle(2);
    vcc_ok = 0; settle(1);
    chk(status == 3, "R8 supply loss power-down", status, 3);
    wait_ph(0); settle(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule